// File: doc/BRIEF.md
# PTP In-Frame Timestamp Rewriter

This block sits in a frame datapath just behind a packet classifier and edits event messages of the precision time protocol while they stream through, one byte per cycle. At the first byte of each frame it latches the classifier verdict (match, UDP carriage, the byte positions of the IP header and of the PTP header), the commanded action and the time of day. For the rest of the frame it swaps selected bytes in place. Every other byte, and every strobe, passes through in the same cycle.

There are three actions. Ingress stamping writes the arrival nanoseconds into the 4-byte reserved field, after adding a latency that depends on link speed. Egress one-step writes a full 10-byte timestamp (48-bit seconds, then 32-bit nanoseconds) into the origin timestamp field of a Sync. Egress two-step leaves the frame untouched and instead raises a one-cycle request to save the local time into a timestamp FIFO. The two rewriting actions also update a modified-frame flag and, on UDP-carried frames, zero the UDP checksum. The frame check sequence is not recomputed here.

Top module: `ptp_ts_rewriter`

## Requirements
- R1: If a frame is not matched, or its action code is 0 (pass), every output byte equals the input byte. out_valid, out_sof and out_eof follow in_valid, in_sof and in_eof in the same cycle. The first byte of a frame is never altered.
- R2: Action code 1 (ingress) on a matched frame replaces the bytes at PTP header positions 16 to 19 with the corrected nanoseconds as a 32-bit big-endian value whose upper two bits are zero.
- R3: The ingress correction adds 208 ns for link_speed 0, 304 ns for link_speed 1 and 2023 ns for link_speed 2 or 3, modulo 1,000,000,000.
- R4: Action code 2 (egress one-step) on a matched frame replaces the bytes at PTP header positions 34 to 43 with the sampled seconds (48 bits, big-endian) followed by the sampled, uncorrected nanoseconds (32 bits, big-endian, upper two bits zero).
- R5: Action code 3 (egress two-step) leaves every byte unchanged. For a matched frame, ts_save_req is high for exactly the one cycle after the first byte is accepted, and it is low at all other times.
- R6: For action codes 1 and 2, bit 7 of the byte at PTP header position 6 is forced to 1 (ingress) or to 0 (egress one-step). The other seven bits of that byte are kept.
- R7: For action codes 1 and 2 with cls_udp set, the two bytes at IP position 26 and 27 are zeroed. Without cls_udp, or under actions 0 and 3, those bytes are kept. Where windows overlap, the timestamp field wins over the flag byte, and the flag byte wins over the checksum.
- R8: The time of day and link_speed are sampled with the first byte. Changes later in the frame have no effect on it.
- R9: The classifier inputs and act_mode are sampled with the first byte. Changes later in the frame have no effect on it.
- R10: While rst_n is low, ts_save_req is 0. A first byte presented during reset raises no save request after reset is released.
- R11: Byte positions count accepted bytes only. Cycles with in_valid low do not advance the position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| in_data | input | 8 | Input byte |
| cls_match | input | 1 | Classifier: frame is a PTP event to handle |
| cls_udp | input | 1 | Classifier: frame is carried over UDP |
| cls_ptp_off | input | OFF_W | Byte position of the PTP header in the frame |
| cls_ip_off | input | OFF_W | Byte position of the IP header in the frame |
| act_mode | input | 2 | 0 pass, 1 ingress, 2 egress one-step, 3 egress two-step |
| link_speed | input | 2 | 0 = 1000 Mb/s, 1 = 100 Mb/s, 2 or 3 = 10 Mb/s |
| tod_sec | input | SEC_W | Time of day, seconds |
| tod_ns | input | NS_W | Time of day, nanoseconds |
| out_valid | output | 1 | Output byte valid |
| out_sof | output | 1 | First byte of frame |
| out_eof | output | 1 | Last byte of frame |
| out_data | output | 8 | Output byte, possibly rewritten |
| ts_save_req | output | 1 | Request to save local time into the timestamp FIFO |

## Verification
The hardest case to reach is a frame whose sideband and time inputs keep changing after its first byte. A design that reads them live instead of from the latched copy would still rewrite correctly whenever those inputs stay steady. The stimulus therefore draws new random classifier, action, speed and time values on every byte after the first, in the directed frames as well as the random ones. It also inserts random idle cycles between bytes, so that a position counter advancing on idle cycles would shift every rewrite window. A nanosecond value just below one second checks the wrap of the latency correction.

// File: rtl/ptp_rw_pkg.sv
package ptp_rw_pkg;

  typedef enum logic [1:0] {
    ACT_PASS        = 2'd0,
    ACT_INGR_NS     = 2'd1,
    ACT_EGR_ONESTEP = 2'd2,
    ACT_EGR_TWOSTEP = 2'd3
  } act_e;

  // Positions relative to the PTP header start
  localparam int FLAG_BYTE_OFF = 6;
  localparam int FLAG_BIT      = 7;
  localparam int NS_FIELD_OFF  = 16;
  localparam int NS_FIELD_LEN  = 4;
  localparam int TS_FIELD_OFF  = 34;
  // Position relative to the IP header start
  localparam int UDP_CSUM_OFF  = 26;

endpackage

// File: rtl/ptp_rw_pos.sv
module ptp_rw_pos #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  output logic [CNT_W-1:0] pos,
  output logic             active
);
  localparam logic [CNT_W-1:0] POS_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] pos_q, pos_d;
  logic             act_q, act_d;

  always_comb begin
    pos_d = pos_q;
    act_d = act_q;
    if (in_valid) begin
      if (in_sof) begin
        pos_d = {{(CNT_W-1){1'b0}}, 1'b1};
        act_d = ~in_eof;
      end else if (act_q) begin
        if (pos_q != POS_MAX) pos_d = pos_q + 1'b1;
        if (in_eof) act_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      act_q <= 1'b0;
    end else begin
      pos_q <= pos_d;
      act_q <= act_d;
    end
  end

  assign pos    = in_sof ? '0 : pos_q;
  assign active = act_q & ~in_sof;
endmodule

// File: rtl/ptp_rw_tod_capture.sv
module ptp_rw_tod_capture #(
  parameter int SEC_W      = 48,
  parameter int NS_W       = 30,
  parameter int LAT_1G     = 208,
  parameter int LAT_100M   = 304,
  parameter int LAT_10M    = 2023,
  parameter int NS_PER_SEC = 1_000_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [1:0]       link_speed,
  input  logic [SEC_W-1:0] tod_sec,
  input  logic [NS_W-1:0]  tod_ns,
  output logic [SEC_W-1:0] sec_q,
  output logic [NS_W-1:0]  ns_raw_q,
  output logic [NS_W-1:0]  ns_ing_q
);
  localparam int SUM_W = NS_W + 1;

  logic [SUM_W-1:0] lat, sum;
  logic [NS_W-1:0]  ns_ing_d;

  always_comb begin
    unique case (link_speed)
      2'd0:    lat = SUM_W'(LAT_1G);
      2'd1:    lat = SUM_W'(LAT_100M);
      default: lat = SUM_W'(LAT_10M);
    endcase
    sum = {1'b0, tod_ns} + lat;
    if (sum >= SUM_W'(NS_PER_SEC)) sum = sum - SUM_W'(NS_PER_SEC);
    ns_ing_d = sum[NS_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q    <= '0;
      ns_raw_q <= '0;
      ns_ing_q <= '0;
    end else if (cap_en) begin
      sec_q    <= tod_sec;
      ns_raw_q <= tod_ns;
      ns_ing_q <= ns_ing_d;
    end
  end
endmodule

// File: rtl/ptp_rw_byte_sel.sv
module ptp_rw_byte_sel
  import ptp_rw_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int OFF_W = 8,
  parameter int SEC_W = 48,
  parameter int NS_W  = 30
) (
  input  logic [7:0]       in_data,
  input  logic [CNT_W-1:0] pos,
  input  logic             active,
  input  act_e             mode,
  input  logic             match,
  input  logic             udp,
  input  logic [OFF_W-1:0] ptp_off,
  input  logic [OFF_W-1:0] ip_off,
  input  logic [SEC_W-1:0] sec,
  input  logic [NS_W-1:0]  ns_raw,
  input  logic [NS_W-1:0]  ns_ing,
  output logic [7:0]       out_data
);
  localparam int NSF_W  = NS_FIELD_LEN * 8;
  localparam int TS_W   = SEC_W + NSF_W;
  localparam int TS_LEN = TS_W / 8;

  logic [TS_W-1:0]  ts_field, ts_shift;
  logic [NSF_W-1:0] ing_field, ing_shift;
  logic [CNT_W-1:0] rel, rel_ts, rel_ns, csum_pos;
  logic             in_ptp, rewr, in_ts, in_ns, at_flag, at_csum;

  always_comb begin
    ts_field  = {sec, {(NSF_W-NS_W){1'b0}}, ns_raw};
    ing_field = {{(NSF_W-NS_W){1'b0}}, ns_ing};
    in_ptp    = pos >= CNT_W'(ptp_off);
    rel       = pos - CNT_W'(ptp_off);
    rel_ts    = rel - CNT_W'(TS_FIELD_OFF);
    rel_ns    = rel - CNT_W'(NS_FIELD_OFF);
    csum_pos  = CNT_W'(ip_off) + CNT_W'(UDP_CSUM_OFF);
    ts_shift  = ts_field << {rel_ts, 3'b000};
    ing_shift = ing_field << {rel_ns, 3'b000};
    rewr      = active & match & ((mode == ACT_INGR_NS) | (mode == ACT_EGR_ONESTEP));
    in_ts     = (mode == ACT_EGR_ONESTEP) & in_ptp & (rel >= CNT_W'(TS_FIELD_OFF))
                & (rel < CNT_W'(TS_FIELD_OFF + TS_LEN));
    in_ns     = (mode == ACT_INGR_NS) & in_ptp & (rel >= CNT_W'(NS_FIELD_OFF))
                & (rel < CNT_W'(NS_FIELD_OFF + NS_FIELD_LEN));
    at_flag   = in_ptp & (rel == CNT_W'(FLAG_BYTE_OFF));
    at_csum   = udp & ((pos == csum_pos) | (pos == csum_pos + 1'b1));

    out_data = in_data;
    if (rewr) begin
      if (in_ts)        out_data = ts_shift[TS_W-1 -: 8];
      else if (in_ns)   out_data = ing_shift[NSF_W-1 -: 8];
      else if (at_flag) out_data[FLAG_BIT] = (mode == ACT_INGR_NS);
      else if (at_csum) out_data = 8'h00;
    end
  end
endmodule

// File: rtl/ptp_ts_rewriter.sv
module ptp_ts_rewriter
  import ptp_rw_pkg::*;
#(
  parameter int CNT_W      = 11,
  parameter int OFF_W      = 8,
  parameter int SEC_W      = 48,
  parameter int NS_W       = 30,
  parameter int LAT_1G     = 208,
  parameter int LAT_100M   = 304,
  parameter int LAT_10M    = 2023,
  parameter int NS_PER_SEC = 1_000_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [7:0]       in_data,
  input  logic             cls_match,
  input  logic             cls_udp,
  input  logic [OFF_W-1:0] cls_ptp_off,
  input  logic [OFF_W-1:0] cls_ip_off,
  input  logic [1:0]       act_mode,
  input  logic [1:0]       link_speed,
  input  logic [SEC_W-1:0] tod_sec,
  input  logic [NS_W-1:0]  tod_ns,
  output logic             out_valid,
  output logic             out_sof,
  output logic             out_eof,
  output logic [7:0]       out_data,
  output logic             ts_save_req
);
  logic             cap_en;
  act_e             mode_q, mode_d;
  logic             match_q, match_d, udp_q, udp_d, save_q, save_d;
  logic [OFF_W-1:0] ptp_q, ptp_d, ip_q, ip_d;
  logic [CNT_W-1:0] pos;
  logic             active;
  logic [SEC_W-1:0] sec_q;
  logic [NS_W-1:0]  ns_raw_q, ns_ing_q;

  assign cap_en = in_valid & in_sof;

  always_comb begin
    mode_d  = mode_q;
    match_d = match_q;
    udp_d   = udp_q;
    ptp_d   = ptp_q;
    ip_d    = ip_q;
    save_d  = 1'b0;
    if (cap_en) begin
      mode_d  = act_e'(act_mode);
      match_d = cls_match;
      udp_d   = cls_udp;
      ptp_d   = cls_ptp_off;
      ip_d    = cls_ip_off;
      save_d  = cls_match & (act_e'(act_mode) == ACT_EGR_TWOSTEP);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= ACT_PASS;
      match_q <= 1'b0;
      udp_q   <= 1'b0;
      ptp_q   <= '0;
      ip_q    <= '0;
      save_q  <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      match_q <= match_d;
      udp_q   <= udp_d;
      ptp_q   <= ptp_d;
      ip_q    <= ip_d;
      save_q  <= save_d;
    end
  end

  ptp_rw_pos #(.CNT_W(CNT_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .pos(pos), .active(active)
  );

  ptp_rw_tod_capture #(
    .SEC_W(SEC_W), .NS_W(NS_W), .LAT_1G(LAT_1G), .LAT_100M(LAT_100M),
    .LAT_10M(LAT_10M), .NS_PER_SEC(NS_PER_SEC)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .link_speed(link_speed),
    .tod_sec(tod_sec), .tod_ns(tod_ns), .sec_q(sec_q),
    .ns_raw_q(ns_raw_q), .ns_ing_q(ns_ing_q)
  );

  ptp_rw_byte_sel #(
    .CNT_W(CNT_W), .OFF_W(OFF_W), .SEC_W(SEC_W), .NS_W(NS_W)
  ) u_sel (
    .in_data(in_data), .pos(pos), .active(active), .mode(mode_q),
    .match(match_q), .udp(udp_q), .ptp_off(ptp_q), .ip_off(ip_q),
    .sec(sec_q), .ns_raw(ns_raw_q), .ns_ing(ns_ing_q), .out_data(out_data)
  );

  assign out_valid   = in_valid;
  assign out_sof     = in_sof;
  assign out_eof     = in_eof;
  assign ts_save_req = save_q;
endmodule

// File: rtl/ptp_rw_checker.sv
module ptp_rw_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_sof,
  input logic [7:0] in_data,
  input logic       cls_match,
  input logic [1:0] act_mode,
  input logic [7:0] out_data,
  input logic       ts_save_req
);
  // R1: the first byte of a frame is never rewritten
  assert_sof_byte_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |-> (out_data == in_data));

  // R5: a save request is always caused by a matched two-step first byte
  assert_save_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ts_save_req |-> $past(in_valid && in_sof && cls_match && act_mode == 2'd3));

  // R5: a matched two-step first byte always yields a save request
  assert_save_issued_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid && in_sof && cls_match && act_mode == 2'd3))
      |-> ts_save_req);

  // R10: no request while reset is held
  always @(posedge clk) begin
    if (!rst_n) assert_reset_quiet_R10: assert (!ts_save_req);
  end
endmodule

bind ptp_ts_rewriter ptp_rw_checker u_ptp_rw_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
  .in_data(in_data), .cls_match(cls_match), .act_mode(act_mode),
  .out_data(out_data), .ts_save_req(ts_save_req)
);

// File: tb/ptp_ts_rewriter_bench.sv
module ptp_ts_rewriter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sof, in_eof;
  logic [7:0]  in_data;
  logic        cls_match, cls_udp;
  logic [7:0]  cls_ptp_off, cls_ip_off;
  logic [1:0]  act_mode, link_speed;
  logic [47:0] tod_sec;
  logic [29:0] tod_ns;
  logic        out_valid, out_sof, out_eof;
  logic [7:0]  out_data;
  logic        ts_save_req;

  int n_tests = 0;
  int n_fail  = 0;

  ptp_ts_rewriter u_ptp_ts_rewriter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .cls_match(cls_match),
    .cls_udp(cls_udp), .cls_ptp_off(cls_ptp_off), .cls_ip_off(cls_ip_off),
    .act_mode(act_mode), .link_speed(link_speed), .tod_sec(tod_sec),
    .tod_ns(tod_ns), .out_valid(out_valid), .out_sof(out_sof),
    .out_eof(out_eof), .out_data(out_data), .ts_save_req(ts_save_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  function automatic int lat_ns(int spd);
    if (spd == 0) return 208;
    if (spd == 1) return 304;
    return 2023;
  endfunction

  function automatic logic [7:0] exp_byte(int i, logic [7:0] orig, int mode,
      bit match, bit udp, int ptp_off, int ip_off, longint sec, int ns_out);
    logic [79:0] ts;
    logic [31:0] nsf;
    int rel;
    ts  = {sec[47:0], 2'b00, ns_out[29:0]};
    nsf = {2'b00, ns_out[29:0]};
    rel = i - ptp_off;
    if (!match || mode == 0 || mode == 3 || i == 0) return orig;
    if (mode == 2 && rel >= 34 && rel < 44) return 8'(ts >> (8 * (43 - rel)));
    if (mode == 1 && rel >= 16 && rel < 20) return 8'(nsf >> (8 * (19 - rel)));
    if (rel == 6) return (mode == 1) ? (orig | 8'h80) : (orig & 8'h7f);
    if (udp && (i == ip_off + 26 || i == ip_off + 27)) return 8'h00;
    return orig;
  endfunction

  task automatic scramble_ctrl();
    cls_match   = 1'($urandom);
    cls_udp     = 1'($urandom);
    cls_ptp_off = 8'($urandom);
    cls_ip_off  = 8'($urandom);
    act_mode    = 2'($urandom);
    link_speed  = 2'($urandom);
    tod_sec     = {16'($urandom), 32'($urandom)};
    tod_ns      = 30'($urandom);
  endtask

  task automatic send_frame(string tag, int mode, bit match, bit udp, int ptp_off,
      int ip_off, int spd, longint sec, int ns, int gap_pct, bit perturb);
    logic [7:0] frm [256];
    logic [7:0] e;
    int  len, ns_out, after_sof, bad_i;
    bit  bad, save_bad, save_exp, want;
    logic [7:0] bad_act, bad_exp;
    logic save_act;
    len      = ptp_off + 44 + int'($urandom_range(0, 20));
    ns_out   = (mode == 1) ? (ns + lat_ns(spd)) % 1000000000 : ns;
    save_exp = match && (mode == 3);
    bad = 0; save_bad = 0; after_sof = -1; bad_i = -1;
    bad_act = 0; bad_exp = 0; save_act = 0;
    for (int k = 0; k < len; k++) frm[k] = 8'($urandom);
    for (int i = 0; i < len; i++) begin
      while (int'($urandom_range(0, 99)) < gap_pct) begin
        @(negedge clk);
        in_valid = 0; in_sof = 0; in_eof = 0; in_data = 8'($urandom);
        if (perturb && after_sof >= 0) scramble_ctrl();
        #1;
        want = (after_sof == 1) ? save_exp : 1'b0;
        if (ts_save_req !== want && !save_bad) begin save_bad = 1; save_act = ts_save_req; end
        if (out_valid !== 1'b0 && !bad) begin bad = 1; bad_i = -2; end
        if (after_sof >= 0) after_sof++;
      end
      @(negedge clk);
      in_valid = 1; in_sof = (i == 0); in_eof = (i == len - 1); in_data = frm[i];
      if (i == 0) begin
        cls_match = match; cls_udp = udp; cls_ptp_off = 8'(ptp_off);
        cls_ip_off = 8'(ip_off); act_mode = 2'(mode); link_speed = 2'(spd);
        tod_sec = sec[47:0]; tod_ns = 30'(ns);
        after_sof = 0;
      end else if (perturb) scramble_ctrl();
      #1;
      want = (after_sof == 1) ? save_exp : 1'b0;
      if (ts_save_req !== want && !save_bad) begin save_bad = 1; save_act = ts_save_req; end
      e = exp_byte(i, frm[i], mode, match, udp, ptp_off, ip_off, sec, ns_out);
      if ((out_data !== e || out_valid !== 1'b1 || out_sof !== in_sof ||
           out_eof !== in_eof) && !bad) begin
        bad = 1; bad_i = i; bad_act = out_data; bad_exp = e;
      end
      after_sof++;
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0;
    #1;
    want = (after_sof == 1) ? save_exp : 1'b0;
    if (ts_save_req !== want && !save_bad) begin save_bad = 1; save_act = ts_save_req; end
    n_tests++;
    if (bad) begin
      n_fail++;
      $display("FAIL %s data byte %0d: actual=%02h expected=%02h", tag, bad_i, bad_act, bad_exp);
    end
    n_tests++;
    if (save_bad) begin
      n_fail++;
      $display("FAIL R5 %s save request: actual=%0b expected=%0b", tag, save_act, ~save_act);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; in_valid = 0; in_sof = 0; in_eof = 0; in_data = 0;
    cls_match = 0; cls_udp = 0; cls_ptp_off = 0; cls_ip_off = 0;
    act_mode = 0; link_speed = 0; tod_sec = 0; tod_ns = 0;
    repeat (3) @(negedge clk);
    // R10: a two-step first byte offered during reset must not request a save
    in_valid = 1; in_sof = 1; cls_match = 1; act_mode = 2'd3;
    #1;
    n_tests++;
    if (ts_save_req !== 1'b0) begin
      n_fail++; $display("FAIL R10 reset: actual=%0b expected=0", ts_save_req);
    end
    @(negedge clk);
    rst_n = 1; in_valid = 0; in_sof = 0;
    @(negedge clk); #1;
    n_tests++;
    if (ts_save_req !== 1'b0 || out_valid !== 1'b0) begin
      n_fail++; $display("FAIL R10 after release: actual=%0b expected=0", ts_save_req);
    end

    // R1: pass action and unmatched frame
    send_frame("R1", 0, 1, 1, 42, 14, 0, 64'h1234, 5000, 0, 0);
    send_frame("R1", 1, 0, 1, 42, 14, 0, 64'h1234, 5000, 0, 0);
    // R2 R3 R6 R7: ingress at each speed code
    send_frame("R2", 1, 1, 1, 42, 14, 0, 64'h10, 123456, 0, 0);
    send_frame("R3", 1, 1, 1, 42, 14, 1, 64'h10, 123456, 0, 0);
    send_frame("R3", 1, 1, 0, 14, 0, 2, 64'h10, 777, 0, 0);
    send_frame("R3", 1, 1, 1, 46, 18, 3, 64'h10, 42, 0, 0);
    // R3: correction wraps past one second
    send_frame("R3", 1, 1, 1, 42, 14, 0, 64'h10, 999999900, 0, 0);
    // R4 R7: one-step over UDP, R6: one-step over Ethernet
    send_frame("R4", 2, 1, 1, 42, 14, 0, 64'hA1B2C3D4E5F6, 987654321, 0, 0);
    send_frame("R6", 2, 1, 0, 14, 3, 1, 64'h0000FFFF0001, 1, 0, 0);
    // R7: two-step leaves checksum alone
    send_frame("R7", 3, 1, 1, 42, 14, 0, 64'h55, 100, 0, 0);
    // R5: two-step matched and unmatched
    send_frame("R5", 3, 1, 0, 20, 0, 0, 64'h77, 9, 0, 0);
    send_frame("R5", 3, 0, 0, 20, 0, 0, 64'h77, 9, 0, 0);
    // R8 R9: inputs change on every byte after the first
    send_frame("R8", 2, 1, 1, 42, 14, 2, 64'h123456789ABC, 500000000, 0, 1);
    send_frame("R9", 1, 1, 1, 42, 14, 1, 64'h42, 999999999, 0, 1);
    // R11: idle cycles inside the frame
    send_frame("R11", 2, 1, 1, 42, 14, 0, 64'hCAFE, 31337, 30, 1);
    send_frame("R11", 1, 1, 1, 50, 22, 2, 64'hCAFE, 31337, 30, 1);

    // Random frames across all actions
    for (int n = 0; n < 60; n++) begin
      int m, po, io, sp;
      bit udp;
      string tag;
      m   = int'($urandom_range(0, 3));
      udp = 1'($urandom);
      po  = udp ? int'($urandom_range(28, 100)) : int'($urandom_range(1, 100));
      io  = udp ? po - 28 : int'($urandom_range(0, 100));
      sp  = int'($urandom_range(0, 3));
      case (m)
        0: tag = "R1";
        1: tag = "R2";
        2: tag = "R4";
        default: tag = "R5";
      endcase
      send_frame(tag, m, 1'($urandom_range(0, 3) != 0), udp, po, io, sp,
                 {16'($urandom), 32'($urandom)}, int'($urandom_range(0, 999999999)),
                 int'($urandom_range(0, 25)), 1);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule